// File: doc/BRIEF.md
# Nibble-Wide DRAM Byte Fetch Sequencer

This block reads one display byte from a dynamic RAM that returns only four data bits per column access. Each byte needs one row strobe and two column strobes. An eight-step one-hot ring sets the order of the work. First the upper address bits go out as the row. The row strobe then latches them. After that, two column addresses are presented one after the other. They differ only in their least significant bit, and a nibble is read after each one. The first nibble becomes the upper half of the byte and the second nibble becomes the lower half.

The block keeps its own screen pointer. The pointer can be loaded from outside. After every completed fetch it steps forward by eight and wraps back by a programmable size when it reaches the end of the screen area. The display logic around the block supplies three things: a qualifier that says a fetch is wanted (active window, no blanking, no competing request), an access-rate setting, and a consume pulse from the pixel serializer. The access rate thins fetches to one ring revolution out of every N.

Top module: `nib_fetch_seq`

## Requirements
- R1: A synchronous reset drives `row_sel`, `col_sel`, `byte_rdy`, `byte_out` and `ram_addr` to zero. It also clears the screen pointer and the rate counter.
- R2: The ring advances one step every clock. The first clock after reset is step 0, and the sequence repeats every eight clocks.
- R3: At step 0 of a fetching revolution, `ram_addr` carries screen pointer bits [15:7] as the row.
- R4: At step 1, `ram_addr` carries {pointer[6:0], 0}. At step 4 it carries {pointer[6:0], 1}.
- R5: In a fetching revolution, `row_sel` is high from step 1 through step 6. `col_sel` is high at steps 2, 3, 5 and 6 and is never high without `row_sel`.
- R6: At step 3, `byte_out` holds the first nibble read in bits [7:4] and zero in bits [3:0]. At step 6, bits [3:0] hold the second nibble read.
- R7: `byte_rdy` rises at step 6 of a fetch and stays high until a cycle with `byte_take` high. If a new byte arrives in the same cycle as `byte_take`, the new byte wins.
- R8: After each fetch, the pointer becomes pointer+8. If that sum is 0x8000 or more, `wrap_size` is subtracted from it.
- R9: A revolution whose fetch qualifier is low at step 0 raises no strobe and leaves `byte_out`, `byte_rdy` and the pointer unchanged.
- R10: A fetch starts only when the rate counter is zero. The counter advances once per revolution, modulo `rate`, and a rate of 0 acts as 1.
- R11: The fetch decision is taken at step 0 and holds for the whole revolution, whatever `fetch_ok` does later in that revolution.
- R12: `addr_load` writes `addr_start` into the pointer and takes priority over the post-fetch advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetch_ok | input | 1 | Fetch wanted; sampled at step 0 |
| rate | input | 4 | Revolutions per fetch (0 treated as 1) |
| addr_load | input | 1 | Load screen pointer |
| addr_start | input | 16 | Value loaded into the pointer |
| wrap_size | input | 16 | Amount subtracted when the pointer passes the screen end |
| ram_dq | input | 4 | Nibble returned by the RAM |
| byte_take | input | 1 | Serializer has consumed the byte |
| ram_addr | output | 9 | Multiplexed row/column address |
| row_sel | output | 1 | Row strobe, active high |
| col_sel | output | 1 | Column strobe, active high |
| byte_out | output | 8 | Assembled byte |
| byte_rdy | output | 1 | Byte available |

## Verification
Every output is registered one clock edge after the ring enters the step that produces it. A value belonging to step k can therefore be read at the falling edge that follows the k-th rising edge of the revolution. The bench runs in whole revolutions that begin right after a step-7 edge. It records all outputs at the eight falling edges and compares each step's entry against the value expected for that step. A pointer load or a qualifier change is driven at the falling edge before the rising edge that must see it. A new pointer value is checked through the row and column addresses of the following revolution.

// File: rtl/nfs_pkg.sv
package nfs_pkg;
   localparam int unsigned NFS_STEPS = 8;

   typedef enum int unsigned {
      ST_ROW   = 0,
      ST_RLAT  = 1,
      ST_CLA   = 2,
      ST_GETA  = 3,
      ST_COLB  = 4,
      ST_CLB   = 5,
      ST_GETB  = 6,
      ST_IDLE  = 7
   } step_e;
endpackage

// File: rtl/nfs_phase_ring.sv
module nfs_phase_ring #(
   parameter int unsigned N = 8
) (
   input  logic         clk,
   input  logic         rst,
   output logic [N-1:0] ring_q,
   output logic [N-1:0] ring_nxt
);
   localparam logic [N-1:0] RING_INIT = {1'b1, {(N-1){1'b0}}};

   generate
      if (N < 2) begin : g_bad
         $error("ring needs at least two steps");
      end
   endgenerate

   assign ring_nxt = {ring_q[N-2:0], ring_q[N-1]};

   always_ff @(posedge clk) begin
      if (rst) ring_q <= RING_INIT;
      else     ring_q <= ring_nxt;
   end
endmodule

// File: rtl/nfs_rate_gate.sv
module nfs_rate_gate #(
   parameter int unsigned RATE_W = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tick,
   input  logic [RATE_W-1:0] rate,
   output logic              slot_free
);
   logic [RATE_W-1:0] acc_q;
   logic [RATE_W:0]   acc_inc;
   logic [RATE_W:0]   rate_eff;

   generate
      if (RATE_W < 1) begin : g_bad
         $error("rate width must be at least one bit");
      end
   endgenerate

   assign rate_eff  = (rate == '0) ? (RATE_W+1)'(1) : {1'b0, rate};
   assign acc_inc   = {1'b0, acc_q} + (RATE_W+1)'(1);
   assign slot_free = (acc_q == '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_q <= '0;
      end else if (tick) begin
         if (acc_inc >= rate_eff) acc_q <= '0;
         else                     acc_q <= acc_inc[RATE_W-1:0];
      end
   end
endmodule

// File: rtl/nfs_datapath.sv
module nfs_datapath
   import nfs_pkg::*;
#(
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned COL_W      = 7,
   parameter int unsigned MUX_W      = 9,
   parameter int unsigned NIB_W      = 4,
   parameter int unsigned STEPS      = 8,
   parameter int unsigned ADDR_STEP  = 8,
   parameter int unsigned SCREEN_END = 32'h8000,
   parameter bit          HI_FIRST   = 1'b1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [STEPS-1:0]    ring_nxt,
   input  logic                fetch_ok,
   input  logic                slot_free,
   input  logic                addr_load,
   input  logic [ADDR_W-1:0]   addr_start,
   input  logic [ADDR_W-1:0]   wrap_size,
   input  logic [NIB_W-1:0]    ram_dq,
   input  logic                byte_take,
   output logic [MUX_W-1:0]    ram_addr,
   output logic                row_sel,
   output logic                col_sel,
   output logic [2*NIB_W-1:0]  byte_q,
   output logic                byte_rdy
);
   localparam int unsigned BYTE_W = 2 * NIB_W;

   logic [ADDR_W-1:0] ptr_q;
   logic [ADDR_W:0]   ptr_sum;
   logic [ADDR_W-1:0] ptr_adv;
   logic              go_q;
   logic              go_now;
   logic [MUX_W-1:0]  row_img;
   logic [MUX_W-1:0]  col_a;
   logic [MUX_W-1:0]  col_b;
   logic [BYTE_W-1:0] img_a;
   logic [BYTE_W-1:0] img_b;

   assign go_now  = fetch_ok && slot_free;
   assign row_img = MUX_W'(ptr_q[ADDR_W-1:COL_W]);
   assign col_a   = MUX_W'({ptr_q[COL_W-1:0], 1'b0});
   assign col_b   = MUX_W'({ptr_q[COL_W-1:0], 1'b1});

   assign ptr_sum = {1'b0, ptr_q} + (ADDR_W+1)'(ADDR_STEP);
   assign ptr_adv = (ptr_sum >= (ADDR_W+1)'(SCREEN_END))
                    ? ADDR_W'(ptr_sum - {1'b0, wrap_size})
                    : ptr_sum[ADDR_W-1:0];

   generate
      if (HI_FIRST) begin : g_hi_first
         assign img_a = {ram_dq, {NIB_W{1'b0}}};
         assign img_b = {{NIB_W{1'b0}}, ram_dq};
      end else begin : g_lo_first
         assign img_a = {{NIB_W{1'b0}}, ram_dq};
         assign img_b = {ram_dq, {NIB_W{1'b0}}};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         ptr_q    <= '0;
         go_q     <= 1'b0;
         ram_addr <= '0;
         row_sel  <= 1'b0;
         col_sel  <= 1'b0;
         byte_q   <= '0;
         byte_rdy <= 1'b0;
      end else begin
         if (addr_load)                       ptr_q <= addr_start;
         else if (ring_nxt[ST_GETB] && go_q)  ptr_q <= ptr_adv;

         if (ring_nxt[ST_ROW]) begin
            go_q <= go_now;
            if (go_now) ram_addr <= row_img;
         end
         if (ring_nxt[ST_RLAT] && go_q) begin
            row_sel  <= 1'b1;
            ram_addr <= col_a;
         end
         if (ring_nxt[ST_CLA] && go_q)  col_sel <= 1'b1;
         if (ring_nxt[ST_GETA] && go_q) byte_q  <= img_a;
         if (ring_nxt[ST_COLB]) begin
            col_sel <= 1'b0;
            if (go_q) ram_addr <= col_b;
         end
         if (ring_nxt[ST_CLB] && go_q)  col_sel <= 1'b1;
         if (ring_nxt[ST_GETB] && go_q) byte_q  <= byte_q | img_b;
         if (ring_nxt[ST_IDLE]) begin
            col_sel <= 1'b0;
            row_sel <= 1'b0;
         end

         if (ring_nxt[ST_GETB] && go_q) byte_rdy <= 1'b1;
         else if (byte_take)            byte_rdy <= 1'b0;
      end
   end
endmodule

// File: rtl/nib_fetch_seq.sv
module nib_fetch_seq
   import nfs_pkg::*;
#(
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned COL_W      = 7,
   parameter int unsigned NIB_W      = 4,
   parameter int unsigned RATE_W     = 4,
   parameter int unsigned ADDR_STEP  = 8,
   parameter int unsigned SCREEN_END = 32'h8000,
   parameter bit          HI_FIRST   = 1'b1,
   localparam int unsigned ROW_W     = ADDR_W - COL_W,
   localparam int unsigned MUX_W     = (ROW_W > COL_W + 1) ? ROW_W : COL_W + 1,
   localparam int unsigned BYTE_W    = 2 * NIB_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              fetch_ok,
   input  logic [RATE_W-1:0] rate,
   input  logic              addr_load,
   input  logic [ADDR_W-1:0] addr_start,
   input  logic [ADDR_W-1:0] wrap_size,
   input  logic [NIB_W-1:0]  ram_dq,
   input  logic              byte_take,
   output logic [MUX_W-1:0]  ram_addr,
   output logic              row_sel,
   output logic              col_sel,
   output logic [BYTE_W-1:0] byte_out,
   output logic              byte_rdy
);
   logic [NFS_STEPS-1:0] ring_q;
   logic [NFS_STEPS-1:0] ring_nxt;
   logic                 slot_free;

   generate
      if (COL_W >= ADDR_W) begin : g_bad_col
         $error("column field must be narrower than the address");
      end
      if (NIB_W < 1) begin : g_bad_nib
         $error("nibble width must be positive");
      end
      if (SCREEN_END > (1 << ADDR_W)) begin : g_bad_end
         $error("screen end exceeds the address space");
      end
   endgenerate

   nfs_phase_ring #(.N(NFS_STEPS)) u_ring (
      .clk      (clk),
      .rst      (rst),
      .ring_q   (ring_q),
      .ring_nxt (ring_nxt)
   );

   nfs_rate_gate #(.RATE_W(RATE_W)) u_rate (
      .clk       (clk),
      .rst       (rst),
      .tick      (ring_nxt[ST_IDLE]),
      .rate      (rate),
      .slot_free (slot_free)
   );

   nfs_datapath #(
      .ADDR_W     (ADDR_W),
      .COL_W      (COL_W),
      .MUX_W      (MUX_W),
      .NIB_W      (NIB_W),
      .STEPS      (NFS_STEPS),
      .ADDR_STEP  (ADDR_STEP),
      .SCREEN_END (SCREEN_END),
      .HI_FIRST   (HI_FIRST)
   ) u_dp (
      .clk        (clk),
      .rst        (rst),
      .ring_nxt   (ring_nxt),
      .fetch_ok   (fetch_ok),
      .slot_free  (slot_free),
      .addr_load  (addr_load),
      .addr_start (addr_start),
      .wrap_size  (wrap_size),
      .ram_dq     (ram_dq),
      .byte_take  (byte_take),
      .ram_addr   (ram_addr),
      .row_sel    (row_sel),
      .col_sel    (col_sel),
      .byte_q     (byte_out),
      .byte_rdy   (byte_rdy)
   );
endmodule

// File: rtl/nfs_chk.sv
module nfs_chk #(
   parameter int unsigned N = 8
) (
   input logic         clk,
   input logic         rst,
   input logic [N-1:0] ring,
   input logic         row_sel,
   input logic         col_sel,
   input logic         byte_rdy,
   input logic         byte_take
);
   // R2: exactly one step active at a time
   a_r2_ring_onehot: assert property (@(posedge clk) disable iff (rst)
      $onehot(ring));

   // R5: column strobe only inside a row cycle
   a_r5_col_in_row: assert property (@(posedge clk) disable iff (rst)
      col_sel |-> row_sel);

   // R5: row strobe begins at step 1
   a_r5_row_starts: assert property (@(posedge clk) disable iff (rst)
      $rose(row_sel) |-> ring[1]);

   // R5: row strobe ends at step 7
   a_r5_row_ends: assert property (@(posedge clk) disable iff (rst)
      $fell(row_sel) |-> ring[N-1]);

   // R7: byte-ready rises only at step 6
   a_r7_rdy_rise: assert property (@(posedge clk) disable iff (rst)
      $rose(byte_rdy) |-> ring[6]);

   // R7: byte-ready holds until consumed
   a_r7_rdy_hold: assert property (@(posedge clk) disable iff (rst)
      (byte_rdy && !byte_take) |=> byte_rdy);
endmodule

bind nib_fetch_seq nfs_chk #(.N(nfs_pkg::NFS_STEPS)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .ring      (ring_q),
   .row_sel   (row_sel),
   .col_sel   (col_sel),
   .byte_rdy  (byte_rdy),
   .byte_take (byte_take)
);

// File: tb/nib_fetch_seq_bench.sv
module nib_fetch_seq_bench;
   localparam int PERIOD = 10;
   localparam int NVEC   = 6;
   // {start address, wrap size}
   localparam logic [31:0] VEC [NVEC] = '{
      {16'h5800, 16'h2800},
      {16'h3000, 16'h5000},
      {16'h7FF8, 16'h5000},
      {16'h7FF8, 16'h2800},
      {16'h6A87, 16'h2800},
      {16'h4C7C, 16'h5000}
   };

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        fetch_ok = 1'b0;
   logic [3:0]  rate = 4'd1;
   logic        addr_load = 1'b0;
   logic [15:0] addr_start = '0;
   logic [15:0] wrap_size = 16'h2800;
   logic [3:0]  ram_dq;
   logic        byte_take = 1'b1;
   logic [8:0]  ram_addr;
   logic        row_sel, col_sel, byte_rdy;
   logic [7:0]  byte_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [8:0] s_addr [8];
   logic [7:0] s_byte [8];
   logic [7:0] s_rs, s_cs, s_rdy;

   nib_fetch_seq u_nib_fetch_seq (
      .clk(clk), .rst(rst), .fetch_ok(fetch_ok), .rate(rate),
      .addr_load(addr_load), .addr_start(addr_start), .wrap_size(wrap_size),
      .ram_dq(ram_dq), .byte_take(byte_take), .ram_addr(ram_addr),
      .row_sel(row_sel), .col_sel(col_sel), .byte_out(byte_out),
      .byte_rdy(byte_rdy)
   );

   always #(PERIOD/2) clk = ~clk;

   // behavioural nibble RAM, contents computed from row and column
   function automatic logic [3:0] nib(input logic [8:0] r, input logic [7:0] c);
      logic [8:0] t;
      t = r ^ (r >> 4) ^ {1'b0, c} ^ {4'b0, c[7:3]} ^ 9'h5;
      return t[3:0];
   endfunction

   function automatic logic [7:0] exp_byte(input logic [15:0] a);
      return {nib(a[15:7], {a[6:0], 1'b0}), nib(a[15:7], {a[6:0], 1'b1})};
   endfunction

   function automatic logic [15:0] exp_next(input logic [15:0] a, input logic [15:0] w);
      logic [16:0] s;
      s = {1'b0, a} + 17'd8;
      if (s >= 17'h08000) s = s - {1'b0, w};
      return s[15:0];
   endfunction

   logic [8:0] row_lat = '0, last_addr = '0;
   logic [7:0] col_lat = '0;
   logic       rs_prev = 1'b0, cs_prev = 1'b0;
   always @(negedge clk) begin
      if (row_sel && !rs_prev) row_lat <= last_addr;
      if (col_sel && !cs_prev) col_lat <= ram_addr[7:0];
      last_addr <= ram_addr;
      rs_prev   <= row_sel;
      cs_prev   <= col_sel;
   end
   assign ram_dq = nib(row_lat, col_lat);

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one revolution, starting just after a step-7 edge
   task automatic rev(input logic ld, input logic [15:0] a, input logic ok0, input logic ok_rest);
      fetch_ok = ok0;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         s_addr[i] = ram_addr;
         s_byte[i] = byte_out;
         s_rs[i]   = row_sel;
         s_cs[i]   = col_sel;
         s_rdy[i]  = byte_rdy;
         if (i == 0) fetch_ok = ok_rest;
         if (i == 6) begin addr_load = ld; addr_start = a; end
         if (i == 7) addr_load = 1'b0;
      end
   endtask

   task automatic chk_fetch(input string tag, input logic [15:0] a);
      chk({tag, " R3 R12 row"}, 32'(s_addr[0]), 32'(a[15:7]));
      chk({tag, " R4 col a"},   32'(s_addr[1]), 32'({a[6:0], 1'b0}));
      chk({tag, " R4 col b"},   32'(s_addr[4]), 32'({a[6:0], 1'b1}));
      chk({tag, " R5 R2 row strobe"}, 32'(s_rs), 32'h7E);
      chk({tag, " R5 col strobe"},    32'(s_cs), 32'h6C);
      chk({tag, " R6 first nibble"},  32'(s_byte[3]), 32'({exp_byte(a)[7:4], 4'h0}));
      chk({tag, " R6 byte"},          32'(s_byte[6]), 32'(exp_byte(a)));
   endtask

   initial begin
      logic [15:0] a, nxt;
      logic [7:0]  held;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 row_sel", 32'(row_sel), 0);
      chk("R1 col_sel", 32'(col_sel), 0);
      chk("R1 byte_rdy", 32'(byte_rdy), 0);
      chk("R1 byte_out", 32'(byte_out), 0);
      chk("R1 ram_addr", 32'(ram_addr), 0);
      rst = 1'b0;
      rev(1'b1, VEC[0][31:16], 1'b0, 1'b0);

      // vector walk: fetch, then pointer advance / wrap
      for (int k = 0; k < NVEC; k++) begin
         a = VEC[k][31:16];
         wrap_size = VEC[k][15:0];
         byte_take = 1'b1;
         rev(1'b0, 16'h0, 1'b1, 1'b1);
         chk_fetch($sformatf("vec%0d", k), a);
         chk("R7 set wins over take", 32'(s_rdy[6]), 1);
         chk("R7 cleared by take", 32'(s_rdy[7]), 0);
         nxt = exp_next(a, VEC[k][15:0]);
         rev(1'b1, (k + 1 < NVEC) ? VEC[(k + 1) % NVEC][31:16] : 16'h0, 1'b1, 1'b1);
         chk("R8 advanced row", 32'(s_addr[0]), 32'(nxt[15:7]));
         chk("R8 advanced col", 32'(s_addr[1]), 32'({nxt[6:0], 1'b0}));
      end

      // R7 hold and R9 idle revolution
      wrap_size = 16'h2800;
      byte_take = 1'b0;
      rev(1'b1, 16'h5000, 1'b1, 1'b1);
      rev(1'b0, 16'h0, 1'b1, 1'b1);
      chk_fetch("hold", 16'h5000);
      chk("R7 held high", 32'(s_rdy[7]), 1);
      held = s_byte[7];
      rev(1'b0, 16'h0, 1'b0, 1'b0);
      chk("R9 no row strobe", 32'(s_rs), 0);
      chk("R9 no col strobe", 32'(s_cs), 0);
      chk("R9 byte unchanged", 32'(s_byte[7]), 32'(held));
      chk("R9 rdy unchanged", 32'(s_rdy), 32'hFF);
      rev(1'b0, 16'h0, 1'b1, 1'b1);
      chk("R9 pointer held row", 32'(s_addr[0]), 32'(16'h5008 >> 7));
      chk("R9 pointer held col", 32'(s_addr[1]), 32'({7'h08, 1'b0}));

      // R11 decision latched at step 0
      byte_take = 1'b1;
      rev(1'b0, 16'h0, 1'b1, 1'b0);
      chk("R11 drop after step 0 still fetches", 32'(s_rs), 32'h7E);
      chk("R11 drop after step 0 byte ready", 32'(s_rdy[6]), 1);
      rev(1'b0, 16'h0, 1'b0, 1'b1);
      chk("R11 raise after step 0 no fetch", 32'(s_rs), 0);

      // R10 access rate
      rate = 4'd3;
      for (int j = 0; j < 6; j++) begin
         rev(1'b0, 16'h0, 1'b1, 1'b1);
         chk($sformatf("R10 rate3 rev%0d", j), 32'(s_rs[1]), (j % 3 == 0) ? 1 : 0);
      end
      rate = 4'd0;
      for (int j = 0; j < 2; j++) begin
         rev(1'b0, 16'h0, 1'b1, 1'b1);
         chk("R10 rate0 acts as 1", 32'(s_rs[1]), 1);
      end

      // R1 / R2 reset mid-run restarts the ring at step 0
      rate = 4'd1;
      @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 mid reset row_sel", 32'(row_sel), 0);
      chk("R1 mid reset byte_rdy", 32'(byte_rdy), 0);
      rst = 1'b0;
      rev(1'b0, 16'h0, 1'b1, 1'b1);
      chk_fetch("after reset R2", 16'h0000);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(PERIOD * 20000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog R2 actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule